// File: doc/BRIEF.md
# SPI Slave Report Transmitter

This block sends report packets to a host processor over SPI, with the block acting as the slave. Local logic pushes payload bytes into a transmit buffer, one byte per cycle, and marks the last byte of each packet. For every queued packet the block sends three parts in turn: a fixed lead byte of 80h, then the payload bytes in the order they were written, then a longitudinal check byte. The check byte is the XOR of every byte sent before it. If bit 7 of that XOR is set, the value is XORed with C0h.

Each byte has its own handshake. The byte is loaded into the shift register first. Only after that is the active-low attention line pulled low to ask the host for eight clocks. If the host leaves a byte unclocked for a set time, the packet is abandoned and sent again from its lead byte. After a set number of failures in a row, the block clears itself and pulses a reset request. A write that arrives while the buffer is full flushes the buffer and queues a short initialize-request packet. From then on, further writes are refused until the host's initialize acknowledgement is reported on `host_init`.

Top module: `spi_report_tx`

## Requirements
- R1: During and right after reset, `spi_atn_n` is 1 and `kbd_locked` and `reset_req` are 0. While reset is held, `spi_miso_oe` is 0.
- R2: SPI mode is CPOL=0, CPHA=1. Each bit, MSB first, is put on `spi_miso` after an SCK rising edge so the host can sample it on the next falling edge. `spi_ss_n` low enables the output (`spi_miso_oe`=1). While `spi_ss_n` is high, `spi_miso` is 0 and SCK edges are ignored.
- R3: Each packet goes out as the byte 80h, then its payload bytes in write order, then the check byte.
- R4: The check byte is the XOR of 80h and all payload bytes. When bit 7 of that XOR is 1, the result is XORed with C0h, so bit 7 is cleared and bit 6 is toggled.
- R5: `spi_atn_n` goes low once per byte, only after that byte is loaded. After the eighth falling SCK edge of a byte it returns high for at least one cycle, so a packet of N payload bytes gives exactly N+2 falling edges of `spi_atn_n`.
- R6: If a byte is not completed within `TIMEOUT_CYC` cycles of `spi_atn_n` going low, then `spi_atn_n` goes high after exactly `TIMEOUT_CYC` low cycles and the packet restarts from its 80h byte.
- R7: On the `MAX_FAILS`-th timeout in a row, `reset_req` pulses for one cycle and the buffer is emptied. After that no attention is raised until new packets are written.
- R8: A packet that completes clears the count of failures in a row.
- R9: The buffer holds `DEPTH` payload bytes, counting from the start of the packet currently being sent. A write to a full buffer discards every queued byte, queues the packet 80h A0h 20h, and sets `kbd_locked` from the next cycle.
- R10: While `kbd_locked` is 1, writes are ignored. A one-cycle pulse on `host_init` clears `kbd_locked`.
- R11: A packet is offered only after its last byte has been written (`wr_last`=1). Queued packets go out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Payload byte write strobe |
| wr_data | input | 8 | Payload byte |
| wr_last | input | 1 | Marks the final payload byte of a packet |
| host_init | input | 1 | Pulse: host has sent initialize or initialize-complete |
| spi_sck | input | 1 | SPI clock from the host |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| spi_atn_n | output | 1 | Active-low request for the host to clock one byte |
| kbd_locked | output | 1 | Writes refused after an overflow |
| reset_req | output | 1 | One-cycle pulse after repeated transfer failures |

## Verification
SCK and slave select each pass through two synchronizer flops. As a result, a data bit shows on `spi_miso` three clock cycles after an SCK rising edge, and `spi_atn_n` goes high three cycles after the eighth falling edge. The bench holds each SCK level for eight cycles and reads MISO at the end of the high half. It also polls attention every cycle, so it catches the one-cycle high gap between bytes. The bench expects `kbd_locked` in the cycle after the write that overflows, and it counts attention-low cycles up to the timeout exactly. Checks that something does not happen look at `spi_atn_n` over a window several hundred cycles long.

// File: rtl/spi_report_tx.sv
module spi_report_tx #(
  parameter int DEPTH       = 32,
  parameter int TIMEOUT_CYC = 6_000_000,
  parameter int MAX_FAILS   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  input  logic       host_init,
  input  logic       spi_sck,
  input  logic       spi_ss_n,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic       spi_atn_n,
  output logic       kbd_locked,
  output logic       reset_req
);

  localparam int AW = $clog2(DEPTH);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int FW = $clog2(MAX_FAILS + 1);
  localparam logic [7:0] LEAD     = 8'h80;
  localparam logic [7:0] INIT_REQ = 8'hA0;

  typedef enum logic [1:0] {IDLE, LOAD, SEND} state_t;
  typedef enum logic [1:0] {PH_PRE, PH_PAY, PH_LRC} phase_t;

  logic [8:0]    mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr, pkt_start, pkt_cnt, used;
  state_t        state;
  phase_t        phase;
  logic [7:0]    sr, lrc, lrc_fold, load_byte;
  logic          miso_q, locked;
  logic [3:0]    bitcnt;
  logic [TW-1:0] timer;
  logic [FW-1:0] fails;
  logic [2:0]    sck_s;
  logic [1:0]    ss_s;
  logic [8:0]    cur_entry;
  logic ss_act, sck_rise, sck_fall, byte_done, timeout, fail_reset;
  logic wr_ok, overflow, pkt_in, pkt_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      ss_s  <= 2'b11;
    end else begin
      sck_s <= {sck_s[1:0], spi_sck};
      ss_s  <= {ss_s[0], spi_ss_n};
    end

  assign ss_act   = ~ss_s[1];
  assign sck_rise = sck_s[1] & ~sck_s[2];
  assign sck_fall = ~sck_s[1] & sck_s[2];

  assign used       = wr_ptr - pkt_start;
  assign cur_entry  = mem[rd_ptr[AW-1:0]];
  assign lrc_fold   = lrc[7] ? (lrc ^ 8'hC0) : lrc;
  assign load_byte  = (phase == PH_PRE) ? LEAD :
                      (phase == PH_PAY) ? cur_entry[7:0] : lrc_fold;
  assign byte_done  = (state == SEND) && ss_act && sck_fall && (bitcnt == 4'd8);
  assign timeout    = (state == SEND) && !byte_done && (timer == TW'(TIMEOUT_CYC - 1));
  assign fail_reset = timeout && (fails == FW'(MAX_FAILS - 1));
  assign wr_ok      = wr_valid && !locked && (used != (AW+1)'(DEPTH));
  assign overflow   = wr_valid && !locked && (used == (AW+1)'(DEPTH));
  assign pkt_in     = wr_ok && wr_last;
  assign pkt_out    = byte_done && (phase == PH_LRC);

  always_ff @(posedge clk)
    if (wr_ok)         mem[wr_ptr[AW-1:0]] <= {wr_last, wr_data};
    else if (overflow) mem[0] <= {1'b1, INIT_REQ};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE;  phase <= PH_PRE;
      wr_ptr <= '0;   rd_ptr <= '0;   pkt_start <= '0;  pkt_cnt <= '0;
      sr <= '0;       lrc <= '0;      miso_q <= 1'b0;   bitcnt <= '0;
      timer <= '0;    fails <= '0;    locked <= 1'b0;   reset_req <= 1'b0;
    end else if (fail_reset) begin
      state <= IDLE;  phase <= PH_PRE;
      wr_ptr <= '0;   rd_ptr <= '0;   pkt_start <= '0;  pkt_cnt <= '0;
      sr <= '0;       lrc <= '0;      miso_q <= 1'b0;   bitcnt <= '0;
      timer <= '0;    fails <= '0;    locked <= 1'b0;   reset_req <= 1'b1;
    end else begin
      reset_req <= 1'b0;
      if (host_init) locked <= 1'b0;
      if (overflow) begin
        wr_ptr    <= (AW+1)'(1);
        rd_ptr    <= '0;
        pkt_start <= '0;
        pkt_cnt   <= (AW+1)'(1);
        locked    <= 1'b1;
        state     <= IDLE;
      end else begin
        if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
        pkt_cnt <= pkt_cnt + (AW+1)'(pkt_in) - (AW+1)'(pkt_out);
        case (state)
          IDLE: if (pkt_cnt != '0) begin
            phase  <= PH_PRE;
            rd_ptr <= pkt_start;
            state  <= LOAD;
          end
          LOAD: begin
            sr     <= load_byte;
            bitcnt <= '0;
            timer  <= '0;
            miso_q <= 1'b0;
            state  <= SEND;
            if (phase == PH_PRE)      lrc <= LEAD;
            else if (phase == PH_PAY) lrc <= lrc ^ cur_entry[7:0];
          end
          SEND: begin
            timer <= timer + 1'b1;
            if (ss_act && sck_rise && bitcnt != 4'd8) begin
              miso_q <= sr[7];
              sr     <= {sr[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
            if (byte_done) begin
              state <= LOAD;
              case (phase)
                PH_PRE: phase <= PH_PAY;
                PH_PAY: begin
                  rd_ptr <= rd_ptr + 1'b1;
                  if (cur_entry[8]) phase <= PH_LRC;
                end
                default: begin
                  pkt_start <= rd_ptr;
                  fails     <= '0;
                  state     <= IDLE;
                end
              endcase
            end else if (timeout) begin
              fails  <= fails + 1'b1;
              phase  <= PH_PRE;
              rd_ptr <= pkt_start;
              state  <= LOAD;
            end
          end
          default: state <= IDLE;
        endcase
      end
    end

  assign spi_atn_n   = (state != SEND);
  assign spi_miso_oe = ss_act;
  assign spi_miso    = ss_act & miso_q;
  assign kbd_locked  = locked;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (AW+1)'(DEPTH));

  // R7
  fail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fails < FW'(MAX_FAILS));

  // R10
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && wr_valid && !fail_reset |=> wr_ptr == $past(wr_ptr));

  // R5
  atn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> spi_atn_n);

  // R6
  timeout_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && !fail_reset && !overflow |=> phase == PH_PRE && rd_ptr == pkt_start && spi_atn_n);

  // R8
  success_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_out && !overflow |=> fails == '0);

endmodule

// File: tb/spi_report_tx_test.sv
module spi_report_tx_test;
  localparam int TO = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_last = 1'b0, host_init = 1'b0;
  logic [7:0] wr_data = '0;
  logic spi_sck = 1'b0, spi_ss_n = 1'b0;
  logic spi_miso, spi_miso_oe, spi_atn_n, kbd_locked, reset_req;

  int checks = 0, errors = 0, cyc = 0, atn_falls = 0, rst_pulses = 0;
  logic atn_prev = 1'b1;
  logic [7:0] pay [0:31];
  int qlen [0:2];
  logic [7:0] qpay [0:2][0:7];

  spi_report_tx #(.DEPTH(32), .TIMEOUT_CYC(TO), .MAX_FAILS(20)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_last(wr_last), .host_init(host_init), .spi_sck(spi_sck),
    .spi_ss_n(spi_ss_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .spi_atn_n(spi_atn_n), .kbd_locked(kbd_locked), .reset_req(reset_req));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (atn_prev && !spi_atn_n) atn_falls++;
    atn_prev = spi_atn_n;
    if (reset_req) rst_pulses++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lrc_of(input int len);
    logic [7:0] acc = 8'h80;
    for (int i = 0; i < len; i++) acc ^= pay[i];
    if (acc[7]) acc ^= 8'hC0;
    return acc;
  endfunction

  task automatic put(input logic [7:0] d, input bit last);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_last = last;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic send_pkt(input int len);
    for (int i = 0; i < len; i++) put(pay[i], i == len - 1);
  endtask

  task automatic get_byte(output logic [7:0] b);
    b = '0;
    while (spi_atn_n) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      spi_sck = 1'b1;
      repeat (8) @(negedge clk);
      b = {b[6:0], spi_miso};
      spi_sck = 1'b0;
      if (i < 7) repeat (8) @(negedge clk);
    end
    while (!spi_atn_n) @(negedge clk);
  endtask

  task automatic expect_pkt(input int len, input string req);
    logic [7:0] b;
    get_byte(b);
    check(b == 8'h80, {req, " lead byte (R3)"}, b, 8'h80);
    for (int i = 0; i < len; i++) begin
      get_byte(b);
      check(b == pay[i], {req, " payload (R3, R2)"}, b, pay[i]);
    end
    get_byte(b);
    check(b == lrc_of(len), {req, " check byte (R4)"}, b, lrc_of(len));
  endtask

  initial begin
    int f0, r0, n, len;
    logic [7:0] b;
    void'($urandom(32'd2024));

    repeat (4) @(negedge clk);
    check(spi_atn_n == 1'b1, "R1 atn in reset", spi_atn_n, 1);
    check(spi_miso_oe == 1'b0, "R1 oe in reset", spi_miso_oe, 0);
    check(kbd_locked == 1'b0 && reset_req == 1'b0, "R1 flags in reset", {kbd_locked, reset_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(spi_atn_n == 1'b1, "R1 atn after reset", spi_atn_n, 1);
    check(spi_miso_oe == 1'b1, "R2 oe with select low", spi_miso_oe, 1);

    // R4 fold case: 80h ^ 01h = 81h -> 41h
    pay[0] = 8'h01;
    send_pkt(1);
    expect_pkt(1, "R4 fold");
    check(lrc_of(1) == 8'h41, "R4 fold value", lrc_of(1), 8'h41);

    // R11: nothing offered before the last byte
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33;
    put(pay[0], 1'b0); put(pay[1], 1'b0);
    repeat (40) @(negedge clk);
    check(spi_atn_n == 1'b1, "R11 no attention before last byte", spi_atn_n, 1);
    put(pay[2], 1'b1);
    expect_pkt(3, "R11 partial");

    // R2: select high gates output and SCK edges
    pay[0] = 8'h55;
    send_pkt(1);
    while (spi_atn_n) @(negedge clk);
    spi_ss_n = 1'b1;
    repeat (4) @(negedge clk);
    check(spi_miso_oe == 1'b0, "R2 oe with select high", spi_miso_oe, 0);
    check(spi_miso == 1'b0, "R2 miso with select high", spi_miso, 0);
    for (int i = 0; i < 8; i++) begin
      spi_sck = 1'b1; repeat (4) @(negedge clk);
      spi_sck = 1'b0; repeat (4) @(negedge clk);
    end
    spi_ss_n = 1'b0;
    repeat (4) @(negedge clk);
    expect_pkt(1, "R2 ignored edges");

    // R3/R4/R5 random single packets
    for (int k = 0; k < 10; k++) begin
      len = 1 + int'($urandom % 6);
      for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
      f0 = atn_falls;
      send_pkt(len);
      expect_pkt(len, "R3 random");
      check(atn_falls - f0 == len + 2, "R5 one attention per byte", atn_falls - f0, len + 2);
    end

    // R11 queued packets in order
    for (int p = 0; p < 3; p++) begin
      qlen[p] = 1 + int'($urandom % 5);
      for (int i = 0; i < qlen[p]; i++) qpay[p][i] = 8'($urandom);
      for (int i = 0; i < qlen[p]; i++) put(qpay[p][i], i == qlen[p] - 1);
    end
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < qlen[p]; i++) pay[i] = qpay[p][i];
      expect_pkt(qlen[p], "R11 queued order");
    end

    // R6 timeout and full retransmit
    pay[0] = 8'hC3; pay[1] = 8'h3C; pay[2] = 8'h7E;
    send_pkt(3);
    get_byte(b);
    check(b == 8'h80, "R6 first lead byte", b, 8'h80);
    get_byte(b);
    check(b == 8'hC3, "R6 first payload", b, 8'hC3);
    while (spi_atn_n) @(negedge clk);
    n = 0;
    while (!spi_atn_n) begin @(negedge clk); n++; end
    check(n == TO, "R6 attention low cycles before abort", n, TO);
    expect_pkt(3, "R6 retransmit");

    // R8 failure count cleared by success
    r0 = rst_pulses;
    for (int rep = 0; rep < 2; rep++) begin
      pay[0] = 8'(8'hA0 + rep); pay[1] = 8'h0F;
      f0 = atn_falls;
      send_pkt(2);
      while (atn_falls < f0 + 20) @(negedge clk);
      expect_pkt(2, "R8 after 19 failures");
    end
    check(rst_pulses == r0, "R8 no reset after cleared count", rst_pulses - r0, 0);

    // R7 reset request after 20 consecutive failures
    r0 = rst_pulses; f0 = atn_falls;
    pay[0] = 8'h99;
    send_pkt(1);
    while (rst_pulses == r0) @(negedge clk);
    check(atn_falls - f0 == 20, "R7 attempts before reset", atn_falls - f0, 20);
    repeat (3) @(negedge clk);
    check(rst_pulses - r0 == 1, "R7 one-cycle reset pulse", rst_pulses - r0, 1);
    f0 = atn_falls;
    repeat (300) @(negedge clk);
    check(spi_atn_n == 1'b1 && atn_falls == f0, "R7 buffer emptied", atn_falls - f0, 0);
    pay[0] = 8'h42;
    send_pkt(1);
    expect_pkt(1, "R7 recovery");

    // R9 overflow and R10 lock
    for (int i = 0; i < 32; i++) put(8'($urandom), (i % 8) == 7);
    check(kbd_locked == 1'b0, "R9 32 bytes fit", kbd_locked, 0);
    put(8'hEE, 1'b1);
    check(kbd_locked == 1'b1, "R9 lock on overflow", kbd_locked, 1);
    pay[0] = 8'hA0;
    expect_pkt(1, "R9 initialize request");
    check(lrc_of(1) == 8'h20, "R9 request check byte", lrc_of(1), 8'h20);
    f0 = atn_falls;
    put(8'h5A, 1'b1);
    repeat (300) @(negedge clk);
    check(spi_atn_n == 1'b1 && atn_falls == f0, "R10 write ignored while locked", atn_falls - f0, 0);
    check(kbd_locked == 1'b1, "R10 still locked", kbd_locked, 1);
    @(negedge clk); host_init = 1'b1;
    @(negedge clk); host_init = 1'b0;
    check(kbd_locked == 1'b0, "R10 unlock by host_init", kbd_locked, 0);
    pay[0] = 8'h6D; pay[1] = 8'h80;
    send_pkt(2);
    expect_pkt(2, "R10 after unlock");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule